// File: doc/BRIEF.md
# 4:2:2 Byte-Stream Demultiplexer with RGB Conversion

This block takes an 8-bit studio-level video stream in which chroma and luma bytes are interleaved, two luma samples to each chroma pair. It rebuilds full pixels, each with its own luma and the chroma pair shared by two neighbouring pixels. It then converts each pixel to red, green and blue with a fixed colour matrix and presents 9-bit components, at most one pixel per clock.

A byte is taken only in cycles where `in_valid` is high. A line-start strobe given with a valid byte marks that byte as the first chroma-blue byte of a group, so the byte phase is set again at every line. The matrix takes 128 off both chroma samples and multiplies them by constants with ten fractional bits. Each channel is rounded half up and clamped to the range 0 to 511. The pipeline latency is fixed and `rgb_valid` marks the output cycles.

Top module: `pix422_rgb`

## Requirements
- R1: While `rst_n` is low and after its release, until the first pixel leaves the pipeline, `rgb_valid` is 0 and `rgb_r`, `rgb_g` and `rgb_b` are 0.
- R2: Valid bytes form groups of four in the order chroma-blue, luma-0, chroma-red, luma-1 (phase 0 to 3). A pixel is emitted for the chroma-red byte (luma-0 with the group's chroma pair) and for the luma-1 byte (luma-1 with the same pair). Chroma-blue and luma-0 bytes emit nothing.
- R3: A valid byte with `in_sol` high is taken as a chroma-blue byte (phase 0). Any pixel the interrupted group had not yet emitted is dropped.
- R4: In a cycle with `in_valid` low, `in_byte` and `in_sol` are ignored and the phase and the held samples are unchanged.
- R5: With Cb' = Cb-128 and Cr' = Cr-128: R = floor((1024*Y + 1404*Cr' + 512)/1024), G = floor((1024*Y - 345*Cb' - 715*Cr' + 512)/1024), B = floor((1024*Y + 1774*Cb' + 512)/1024).
- R6: A channel result below 0 is output as 0 and one above 511 as 511.
- R7: `rgb_valid` is high after the second rising edge that follows the edge capturing a pixel-emitting byte, and only then. Outputs keep their last value while `rgb_valid` is low.
- R8: A pixel with Cb = Cr = 128 gives R = G = B = Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (27 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_byte` and `in_sol` |
| in_sol | input | 1 | Line start; this byte is chroma-blue |
| in_byte | input | 8 | Multiplexed luma/chroma byte |
| rgb_valid | output | 1 | RGB outputs carry a new pixel |
| rgb_r | output | 9 | Red component |
| rgb_g | output | 9 | Green component |
| rgb_b | output | 9 | Blue component |

## Verification
The bench sends line strobes in the middle of a group. A design that kept the stale phase would emit a pixel built from the wrong bytes, and one that did not drop the pending pixel would give an output the model does not expect. Idle cycles with random bytes and strobes are placed inside groups, which catches a design that lets invalid bytes advance the phase or overwrite a held sample. Extreme chroma values push green and red below zero and blue near its maximum: a design with wrong clamping would wrap a negative sum to a large code, and a wrong rounding offset would be one code off. Every output is also checked against its expected arrival cycle, so an extra or missing pipeline stage is reported.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int PIX_W      = 8;
    localparam int CHROMA_MID = 128;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_t;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
    } pix_t;

endpackage

// File: rtl/pix_demux.sv
module pix_demux
    import pix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_byte,
    output pix_t             pix_o,
    output logic             pix_vld_o
);

    typedef struct packed {
        phase_t           phase;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] y0;
        logic [PIX_W-1:0] cr;
        pix_t             pix;
        logic             vld;
    } dmx_st_t;

    dmx_st_t st_d, st_q;
    phase_t  ph_now;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        ph_now   = in_sol ? PH_CB : st_q.phase;
        if (in_valid) begin
            unique case (ph_now)
                PH_CB: st_d.cb = in_byte;
                PH_Y0: st_d.y0 = in_byte;
                PH_CR: begin
                    st_d.cr     = in_byte;
                    st_d.pix.y  = st_q.y0;
                    st_d.pix.cb = st_q.cb;
                    st_d.pix.cr = in_byte;
                    st_d.vld    = 1'b1;
                end
                PH_Y1: begin
                    st_d.pix.y  = in_byte;
                    st_d.pix.cb = st_q.cb;
                    st_d.pix.cr = st_q.cr;
                    st_d.vld    = 1'b1;
                end
                default: ;
            endcase
            st_d.phase = phase_t'(ph_now + 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o     = st_q.pix;
    assign pix_vld_o = st_q.vld;

    assert_sol_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> (st_q.phase == PH_Y0 && !st_q.vld));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.phase) && $stable(st_q.cb) && $stable(st_q.y0)
                       && $stable(st_q.cr) && !st_q.vld));

    assert_y0_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sol && st_q.phase == PH_Y0) |=> !st_q.vld);

    assert_y1_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sol && st_q.phase == PH_Y1) |=> (st_q.vld && st_q.pix.y == $past(in_byte)));

endmodule

// File: rtl/rnd_clamp.sv
module rnd_clamp #(
    parameter int ACC_W  = 23,
    parameter int FRAC_W = 10,
    parameter int OUT_W  = 9
) (
    input  logic signed [ACC_W-1:0] sum_i,
    output logic        [OUT_W-1:0] val_o
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << OUT_W) - 1);

    logic signed [ACC_W-1:0] rnd_s;
    logic signed [ACC_W-1:0] int_s;

    always_comb begin
        rnd_s = sum_i + HALF;
        int_s = rnd_s >>> FRAC_W;
        if (int_s < 0) begin
            val_o = '0;
        end else if (int_s > MAXV) begin
            val_o = MAXV[OUT_W-1:0];
        end else begin
            val_o = int_s[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/rgb_matrix.sv
module rgb_matrix
    import pix_pkg::*;
#(
    parameter int FRAC_W = 10,
    parameter int COEF_W = 12,
    parameter int OUT_W  = 9,
    parameter int K_RV   = 1404,
    parameter int K_GU   = 345,
    parameter int K_GV   = 715,
    parameter int K_BU   = 1774
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pix_t             pix_i,
    input  logic             pix_vld_i,
    output logic [OUT_W-1:0] rgb_r,
    output logic [OUT_W-1:0] rgb_g,
    output logic [OUT_W-1:0] rgb_b,
    output logic             rgb_vld
);

    localparam int ACC_W = PIX_W + COEF_W + 3;
    localparam int N_CH  = 3;

    localparam logic signed [ACC_W-1:0] C_RV = ACC_W'(K_RV);
    localparam logic signed [ACC_W-1:0] C_GU = ACC_W'(K_GU);
    localparam logic signed [ACC_W-1:0] C_GV = ACC_W'(K_GV);
    localparam logic signed [ACC_W-1:0] C_BU = ACC_W'(K_BU);
    localparam logic signed [ACC_W-1:0] MID  = ACC_W'(CHROMA_MID);

    typedef struct packed {
        logic                      vld;
        logic [ACC_W-1:0]          yf;
        logic [N_CH-1:0][ACC_W-1:0] term;
    } prod_st_t;

    typedef struct packed {
        logic                      vld;
        logic [N_CH-1:0][OUT_W-1:0] ch;
    } out_st_t;

    prod_st_t pr_d, pr_q;
    out_st_t  ou_d, ou_q;

    logic signed [ACC_W-1:0] cbc, crc;
    logic [N_CH-1:0][OUT_W-1:0] ch_val;

    // Stage 1: remove chroma offset and form the constant products
    always_comb begin
        cbc = $signed(ACC_W'(pix_i.cb)) - MID;
        crc = $signed(ACC_W'(pix_i.cr)) - MID;
        pr_d         = pr_q;
        pr_d.vld     = pix_vld_i;
        if (pix_vld_i) begin
            pr_d.yf      = ACC_W'({pix_i.y, {FRAC_W{1'b0}}});
            pr_d.term[0] = C_RV * crc;
            pr_d.term[1] = -((C_GU * cbc) + (C_GV * crc));
            pr_d.term[2] = C_BU * cbc;
        end
    end

    // Stage 2: add luma, round, clamp per channel
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic signed [ACC_W-1:0] sum_c;
        assign sum_c = $signed(pr_q.yf) + $signed(pr_q.term[c]);
        rnd_clamp #(
            .ACC_W (ACC_W),
            .FRAC_W(FRAC_W),
            .OUT_W (OUT_W)
        ) u_rc (
            .sum_i(sum_c),
            .val_o(ch_val[c])
        );
    end

    always_comb begin
        ou_d     = ou_q;
        ou_d.vld = pr_q.vld;
        if (pr_q.vld) begin
            ou_d.ch = ch_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_q <= '0;
            ou_q <= '0;
        end else begin
            pr_q <= pr_d;
            ou_q <= ou_d;
        end
    end

    assign rgb_r   = ou_q.ch[0];
    assign rgb_g   = ou_q.ch[1];
    assign rgb_b   = ou_q.ch[2];
    assign rgb_vld = ou_q.vld;

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld_i |=> ##1 rgb_vld);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld_i |=> ##1 !rgb_vld);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rgb_vld |-> ($stable(rgb_r) && $stable(rgb_g) && $stable(rgb_b)));

    assert_gray_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_i && pix_i.cb == PIX_W'(CHROMA_MID) && pix_i.cr == PIX_W'(CHROMA_MID))
        |=> ##1 (rgb_r == rgb_g && rgb_g == rgb_b));

endmodule

// File: rtl/pix422_rgb.sv
module pix422_rgb
    import pix_pkg::*;
#(
    parameter int FRAC_W = 10,
    parameter int COEF_W = 12,
    parameter int OUT_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_byte,
    output logic             rgb_valid,
    output logic [OUT_W-1:0] rgb_r,
    output logic [OUT_W-1:0] rgb_g,
    output logic [OUT_W-1:0] rgb_b
);

    pix_t pix_w;
    logic pix_vld_w;

    pix_demux u_demux (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_byte  (in_byte),
        .pix_o    (pix_w),
        .pix_vld_o(pix_vld_w)
    );

    rgb_matrix #(
        .FRAC_W(FRAC_W),
        .COEF_W(COEF_W),
        .OUT_W (OUT_W)
    ) u_matrix (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_i    (pix_w),
        .pix_vld_i(pix_vld_w),
        .rgb_r    (rgb_r),
        .rgb_g    (rgb_g),
        .rgb_b    (rgb_b),
        .rgb_vld  (rgb_valid)
    );

endmodule

// File: tb/pix422_rgb_test.sv
module pix422_rgb_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sol = 1'b0;
    logic [7:0] in_byte = '0;
    logic       rgb_valid;
    logic [8:0] rgb_r, rgb_g, rgb_b;

    pix422_rgb uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_byte  (in_byte),
        .rgb_valid(rgb_valid),
        .rgb_r    (rgb_r),
        .rgb_g    (rgb_g),
        .rgb_b    (rgb_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    r;
        int    g;
        int    b;
        int    due;
        string req;
    } exp_t;

    exp_t  expq[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R5";

    int m_ph = 0;
    int m_cb = 0;
    int m_y0 = 0;
    int m_cr = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // R5/R6 channel arithmetic
    function automatic int chan(int y, int term);
        int s;
        int q;
        s = y * 1024 + term + 512;
        q = s >>> 10;
        if (q < 0) q = 0;
        if (q > 511) q = 511;
        return q;
    endfunction

    function automatic void push_pix(int y, int cb, int cr);
        exp_t e;
        e.r   = chan(y, 1404 * (cr - 128));
        e.g   = chan(y, -(345 * (cb - 128) + 715 * (cr - 128)));
        e.b   = chan(y, 1774 * (cb - 128));
        e.due = cyc + 3;
        e.req = cur_req;
        expq.push_back(e);
    endfunction

    task automatic send(bit v, bit s, int b);
        @(negedge clk);
        in_valid = v;
        in_sol   = s;
        in_byte  = 8'(b);
        if (v) begin
            if (s) m_ph = 0;
            case (m_ph)
                0: m_cb = b;
                1: m_y0 = b;
                2: begin m_cr = b; push_pix(m_y0, m_cb, b); end
                default: push_pix(b, m_cb, m_cr);
            endcase
            m_ph = (m_ph + 1) % 4;
        end
    endtask

    task automatic group(int cb, int y0, int cr, int y1, bit sol);
        send(1'b1, sol, cb);
        send(1'b1, 1'b0, y0);
        send(1'b1, 1'b0, cr);
        send(1'b1, 1'b0, y1);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send(1'b0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
    endtask

    task automatic finish_up();
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R7: %0d pixels never appeared, expected 0 pending", expq.size());
        end
        checks++;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Output checker
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (expq.size() > 0 && expq[0].due < cyc) begin
                exp_t m;
                m = expq.pop_front();
                checks++;
                fails++;
                $display("FAIL R7: pixel due in cycle %0d missing, actual rgb_valid=0 expected 1", m.due);
            end
            if (rgb_valid) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R2: unexpected pixel rgb=%0d,%0d,%0d expected none", rgb_r, rgb_g, rgb_b);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.due != cyc) begin
                        fails++;
                        $display("FAIL R7: pixel at cycle %0d expected cycle %0d", cyc, e.due);
                    end
                    if (int'(rgb_r) != e.r || int'(rgb_g) != e.g || int'(rgb_b) != e.b) begin
                        fails++;
                        $display("FAIL %s: rgb=%0d,%0d,%0d expected %0d,%0d,%0d",
                                 e.req, rgb_r, rgb_g, rgb_b, e.r, e.g, e.b);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'h1c0de));
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (rgb_valid !== 1'b0 || rgb_r !== 9'd0 || rgb_g !== 9'd0 || rgb_b !== 9'd0) begin
            fails++;
            $display("FAIL R1: in reset valid=%b rgb=%0d,%0d,%0d expected 0,0,0,0",
                     rgb_valid, rgb_r, rgb_g, rgb_b);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rgb_valid !== 1'b0 || rgb_r !== 9'd0) begin
            fails++;
            $display("FAIL R1: after release valid=%b r=%0d expected 0,0", rgb_valid, rgb_r);
        end

        // R8: neutral chroma gives gray
        cur_req = "R8";
        group(128, 16, 128, 235, 1'b1);
        group(128, 0, 128, 255, 1'b0);
        // R2: ordinary back-to-back groups
        cur_req = "R2";
        group(90, 81, 240, 41, 1'b0);
        group(240, 110, 110, 29, 1'b0);
        // R5: rounding at mid values
        cur_req = "R5";
        group(60, 100, 200, 101, 1'b0);
        group(129, 127, 127, 128, 1'b0);
        // R6: clamping at both ends of chroma
        cur_req = "R6";
        group(255, 0, 255, 255, 1'b0);
        group(0, 255, 0, 0, 1'b0);
        group(255, 255, 0, 3, 1'b0);
        // R4: idle cycles with junk inside a group
        cur_req = "R4";
        send(1'b1, 1'b0, 200);
        idle(3);
        send(1'b1, 1'b0, 70);
        idle(2);
        send(1'b1, 1'b0, 30);
        idle(4);
        send(1'b1, 1'b0, 180);
        // R3: line strobe after luma-0, then after chroma-red
        cur_req = "R3";
        send(1'b1, 1'b1, 50);
        send(1'b1, 1'b0, 60);
        group(10, 20, 230, 40, 1'b1);
        send(1'b1, 1'b0, 170);
        send(1'b1, 1'b0, 140);
        send(1'b1, 1'b0, 90);
        group(200, 150, 60, 77, 1'b1);
        // Random traffic, R2/R4/R5 under mixed patterns
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            bit v;
            bit s;
            v = ($urandom_range(0, 9) < 8);
            s = ($urandom_range(0, 49) == 0);
            send(v, s, int'($urandom_range(0, 255)));
        end
        send(1'b0, 1'b0, 0);
        repeat (8) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            finish_up();
        end
    end

endmodule